// File: doc/BRIEF.md
# Phase-qualified 32-to-64-bit write port packer

This block sits behind a 32-bit processor bus whose transfers are qualified by a slow strobe, the phase signal, that alternates level on every clock edge. It gathers bus halves into 64-bit words and emits one write pulse per completed transfer. Each pulse carries the word, the target address, the mask-select code and a search launch flag. Targets are either 64-bit words or 32-bit registers, and the top address bit tells them apart. Downstream logic decodes the address further, returns reads and drives the tristate bus.

Two modes exist. In normal mode, one 32-bit half moves per phase period. A 64-bit target is loaded by writing its upper half first and its lower half second. The lower-half write issues the full word. In fast mode, both halves move within one phase period. The high-phase edge carries the upper half and the low-phase edge carries the lower half plus the address and control. The mode lives in a one-bit control register that the bus itself writes, and it resets to normal.

Top module: `phase_wr_port`

## Requirements
- R1: After reset, no write pulse or error pulse is present, the mode is normal (fast_mode_o=0), and the upper-half holding register is zero. A lower-half write that has no preceding upper half therefore issues zeros in bits 63:32.
- R2: In normal mode, the bus is only sampled on a rising edge where phase_i=0, cs_ni=0 and wr_ni=0. Bus activity on a phase_i=1 edge, or with cs_ni=1 or wr_ni=1, produces no pulse and changes no state.
- R3: In normal mode, for a 64-bit target (addr_i[5]=0), addr_i[0]=1 stores data_i as the upper half and issues no pulse. addr_i[0]=0 issues, one cycle after the sampling edge, wr_wide_o=1 with wr_data_o = {stored upper, data_i} and wr_addr_o = addr_i.
- R4: In normal mode, a write to a 32-bit register (addr_i[5]=1) issues wr_wide_o=0, wr_addr_o = addr_i with all six bits, and wr_data_o = data_i zero-extended.
- R5: In fast mode, the bus value on the phase_i=1 edge becomes bits 63:32. The following phase_i=0 edge supplies bits 31:0 and the control, and a 64-bit write is issued.
- R6: In fast mode, addr_i[0] is ignored, so wr_addr_o[0]=0. A 32-bit register write uses only the phase_i=0 sample, zero-extended.
- R7: A 32-bit write to address 6'h3E sets the mode from data_i[0] (1 = fast). The new mode applies from the next transfer.
- R8: Mask-select codes 0 to 11 pass unchanged on wr_msel_o with the pulse.
- R9: Mask-select codes 12 to 15 on a sampled write produce a one-cycle msel_err_o instead of a write pulse. They do not update the normal-mode upper-half register or the mode.
- R10: wr_srch_o rises with the pulse only when srch_ni=0 was sampled together with a 64-bit write to the comparand word address 6'h00. In every other case srch_ni is ignored.
- R11: Every write pulse lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| phase_i | input | 1 | Phase strobe, toggles each cycle |
| cs_ni | input | 1 | Bus select, active low |
| wr_ni | input | 1 | Write when low, read when high |
| addr_i | input | 6 | Register address |
| data_i | input | 32 | Bus data |
| msel_i | input | 4 | Mask-select code |
| srch_ni | input | 1 | Search request, active low |
| wr_vld_o | output | 1 | One-cycle write pulse |
| wr_wide_o | output | 1 | 1 = 64-bit target, 0 = 32-bit register |
| wr_addr_o | output | 6 | Issued address |
| wr_data_o | output | 64 | Issued data |
| wr_msel_o | output | 4 | Mask-select code for the write |
| wr_srch_o | output | 1 | Search launch with the write |
| msel_err_o | output | 1 | Illegal mask-select pulse |
| fast_mode_o | output | 1 | Current mode, 1 = fast |

## Verification
The checker watches several properties on every cycle. Pulses only follow low-phase edges and last one cycle. An error pulse never coincides with a write and always follows an out-of-range code. Issued codes are legal, a search only accompanies a 64-bit write, 64-bit addresses are even, and the mode changes only on a control-register write. Data values need the bench's scenarios: pairing of halves across the two modes, the zeroed upper half after reset, a held upper half surviving an illegal code, and the address bit being dropped in fast mode.

// File: rtl/phase_wr_pkg.sv
`timescale 1ns/1ps
package phase_wr_pkg;
   typedef enum logic {
      MODE_NORMAL = 1'b0,
      MODE_FAST   = 1'b1
   } wr_mode_e;

   function automatic logic code_legal(int unsigned code, int unsigned limit);
      return code < limit;
   endfunction
endpackage

// File: rtl/phase_wr_mode.sv
`timescale 1ns/1ps
module phase_wr_mode
   import phase_wr_pkg::*;
(
   input  logic clk_i,
   input  logic rst_ni,
   input  logic set_i,
   input  logic val_i,
   output logic fast_o
);
   wr_mode_e mode_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    mode_q <= MODE_NORMAL;
      else if (set_i) mode_q <= val_i ? MODE_FAST : MODE_NORMAL;
   end

   assign fast_o = (mode_q == MODE_FAST);
endmodule

// File: rtl/phase_wr_hold.sv
`timescale 1ns/1ps
module phase_wr_hold #(
   parameter int HALF_W   = 32,
   parameter bit HOLD_CLR = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              load_i,
   input  logic [HALF_W-1:0] val_i,
   output logic [HALF_W-1:0] q_o
);
   logic [HALF_W-1:0] hold_q;

   generate
      if (HOLD_CLR) begin : g_clr
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)     hold_q <= '0;
            else if (load_i) hold_q <= val_i;
         end
      end else begin : g_noclr
         always_ff @(posedge clk_i) begin
            if (load_i) hold_q <= val_i;
         end
      end
   endgenerate

   assign q_o = hold_q;
endmodule

// File: rtl/phase_wr_issue.sv
`timescale 1ns/1ps
module phase_wr_issue #(
   parameter int WORD_W = 64,
   parameter int ADDR_W = 6,
   parameter int MSEL_W = 4
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              fire_i,
   input  logic              err_i,
   input  logic              wide_i,
   input  logic              srch_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [WORD_W-1:0] data_i,
   input  logic [MSEL_W-1:0] msel_i,
   output logic              vld_o,
   output logic              err_o,
   output logic              wide_o,
   output logic              srch_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [WORD_W-1:0] data_o,
   output logic [MSEL_W-1:0] msel_o
);
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         vld_o  <= 1'b0;
         err_o  <= 1'b0;
         srch_o <= 1'b0;
         wide_o <= 1'b0;
         addr_o <= '0;
         data_o <= '0;
         msel_o <= '0;
      end else begin
         vld_o  <= fire_i;
         err_o  <= err_i;
         srch_o <= fire_i & srch_i;
         if (fire_i) begin
            wide_o <= wide_i;
            addr_o <= addr_i;
            data_o <= data_i;
            msel_o <= msel_i;
         end
      end
   end
endmodule

// File: rtl/phase_wr_port.sv
`timescale 1ns/1ps
module phase_wr_port
   import phase_wr_pkg::*;
#(
   parameter int HALF_W    = 32,
   parameter int ADDR_W    = 6,
   parameter int MSEL_W    = 4,
   parameter int NUM_MASKS = 12,
   parameter int CMP_ADDR  = 0,
   parameter int CTRL_ADDR = 62,
   parameter bit HOLD_CLR  = 1'b1
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                phase_i,
   input  logic                cs_ni,
   input  logic                wr_ni,
   input  logic [ADDR_W-1:0]   addr_i,
   input  logic [HALF_W-1:0]   data_i,
   input  logic [MSEL_W-1:0]   msel_i,
   input  logic                srch_ni,
   output logic                wr_vld_o,
   output logic                wr_wide_o,
   output logic [ADDR_W-1:0]   wr_addr_o,
   output logic [2*HALF_W-1:0] wr_data_o,
   output logic [MSEL_W-1:0]   wr_msel_o,
   output logic                wr_srch_o,
   output logic                msel_err_o,
   output logic                fast_mode_o
);
   localparam int WORD_W = 2 * HALF_W;
   localparam logic [ADDR_W-1:0] CMP_A  = ADDR_W'(CMP_ADDR);
   localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

   // elaboration-time parameter checks
   generate
      if (ADDR_W < 2) begin : g_bad_addr
         $error("ADDR_W must be at least 2");
      end
      if (NUM_MASKS < 1 || NUM_MASKS > (1 << MSEL_W)) begin : g_bad_masks
         $error("NUM_MASKS must fit the mask-select code");
      end
      if (CMP_A[ADDR_W-1] || CMP_A[0]) begin : g_bad_cmp
         $error("comparand address must be an even 64-bit target");
      end
      if (!CTRL_A[ADDR_W-1] || CTRL_A[0]) begin : g_bad_ctrl
         $error("control address must be an even 32-bit register");
      end
   endgenerate

   logic              fast_q;
   logic [HALF_W-1:0] upper_q;
   logic              sample_act, code_ok, tgt_wide, upper_only;
   logic              fire, err, hold_load, srch_hit, mode_set;
   logic [ADDR_W-1:0] eff_addr;
   logic [WORD_W-1:0] word;

   always_comb begin
      sample_act = !phase_i && !cs_ni && !wr_ni;
      code_ok    = code_legal(int'(msel_i), NUM_MASKS);
      tgt_wide   = !addr_i[ADDR_W-1];
      eff_addr   = fast_q ? {addr_i[ADDR_W-1:1], 1'b0} : addr_i;
      upper_only = !fast_q && tgt_wide && addr_i[0];
      fire       = sample_act && code_ok && !upper_only;
      err        = sample_act && !code_ok;
      hold_load  = fast_q ? phase_i : (sample_act && code_ok && upper_only);
      word       = tgt_wide ? {upper_q, data_i} : {{HALF_W{1'b0}}, data_i};
      srch_hit   = tgt_wide && (eff_addr == CMP_A) && !srch_ni;
      mode_set   = fire && !tgt_wide && (eff_addr == CTRL_A);
   end

   phase_wr_mode mode_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (mode_set),
      .val_i  (data_i[0]),
      .fast_o (fast_q)
   );

   phase_wr_hold #(.HALF_W(HALF_W), .HOLD_CLR(HOLD_CLR)) hold_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (hold_load),
      .val_i  (data_i),
      .q_o    (upper_q)
   );

   phase_wr_issue #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .MSEL_W(MSEL_W)) issue_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .fire_i (fire),
      .err_i  (err),
      .wide_i (tgt_wide),
      .srch_i (srch_hit),
      .addr_i (eff_addr),
      .data_i (word),
      .msel_i (msel_i),
      .vld_o  (wr_vld_o),
      .err_o  (msel_err_o),
      .wide_o (wr_wide_o),
      .srch_o (wr_srch_o),
      .addr_o (wr_addr_o),
      .data_o (wr_data_o),
      .msel_o (wr_msel_o)
   );

   assign fast_mode_o = fast_q;
endmodule

// File: rtl/phase_wr_port_chk.sv
`timescale 1ns/1ps
module phase_wr_port_chk #(
   parameter int ADDR_W    = 6,
   parameter int MSEL_W    = 4,
   parameter int NUM_MASKS = 12,
   parameter int CTRL_ADDR = 62
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              phase_i,
   input logic [MSEL_W-1:0] msel_i,
   input logic              wr_vld_o,
   input logic              wr_wide_o,
   input logic [ADDR_W-1:0] wr_addr_o,
   input logic [MSEL_W-1:0] wr_msel_o,
   input logic              wr_srch_o,
   input logic              msel_err_o,
   input logic              fast_mode_o
);
   localparam logic [MSEL_W:0]   LIM    = (MSEL_W+1)'(NUM_MASKS);
   localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

   a_r2_low_phase_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_vld_o |-> !$past(phase_i));

   a_r11_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_vld_o |=> !wr_vld_o);

   a_r9_err_blocks_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
      msel_err_o |-> !wr_vld_o);

   a_r9_err_from_bad_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
      msel_err_o |-> ({1'b0, $past(msel_i)} >= LIM));

   a_r8_code_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_vld_o |-> ({1'b0, wr_msel_o} < LIM));

   a_r10_srch_with_wide: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_srch_o |-> (wr_vld_o && wr_wide_o));

   a_r3_wide_even: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_vld_o && wr_wide_o) |-> !wr_addr_o[0]);

   a_r7_mode_by_ctrl: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(fast_mode_o) |-> (wr_vld_o && !wr_wide_o && wr_addr_o == CTRL_A));
endmodule

bind phase_wr_port phase_wr_port_chk #(
   .ADDR_W(ADDR_W), .MSEL_W(MSEL_W), .NUM_MASKS(NUM_MASKS), .CTRL_ADDR(CTRL_ADDR)
) chk_i (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .phase_i     (phase_i),
   .msel_i      (msel_i),
   .wr_vld_o    (wr_vld_o),
   .wr_wide_o   (wr_wide_o),
   .wr_addr_o   (wr_addr_o),
   .wr_msel_o   (wr_msel_o),
   .wr_srch_o   (wr_srch_o),
   .msel_err_o  (msel_err_o),
   .fast_mode_o (fast_mode_o)
);

// File: tb/phase_wr_port_tb_top.sv
`timescale 1ns/1ps
module phase_wr_port_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        phase;
   logic        cs_n = 1'b1, wr_n = 1'b1, srch_n = 1'b1;
   logic [5:0]  addr = '0;
   logic [31:0] data = '0;
   logic [3:0]  msel = '0;
   logic        vld, wide, srch, err, fast;
   logic [5:0]  oaddr;
   logic [63:0] odata;
   logic [3:0]  omsel;

   int total = 0;
   int bad   = 0;

   logic        m_fast = 1'b0;
   logic [31:0] m_hold = '0;

   always #2 clk = ~clk;

   always @(posedge clk) begin
      if (!rst_n) phase <= 1'b1;
      else        phase <= ~phase;
   end

   phase_wr_port dut_i (
      .clk_i(clk), .rst_ni(rst_n), .phase_i(phase), .cs_ni(cs_n), .wr_ni(wr_n),
      .addr_i(addr), .data_i(data), .msel_i(msel), .srch_ni(srch_n),
      .wr_vld_o(vld), .wr_wide_o(wide), .wr_addr_o(oaddr), .wr_data_o(odata),
      .wr_msel_o(omsel), .wr_srch_o(srch), .msel_err_o(err), .fast_mode_o(fast)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic idle();
      cs_n = 1'b1; wr_n = 1'b1; srch_n = 1'b1; data = '0; addr = '0; msel = '0;
   endtask

   // one transfer: high-phase edge then low-phase edge, result checked after
   task automatic xfer(input logic c_n, input logic w_n, input logic [5:0] a,
                       input logic [31:0] lo, input logic [31:0] hi,
                       input logic [3:0] ms, input logic s_n, input logic hi_act);
      logic act, legal, twide, e_vld, e_err, e_srch;
      logic [5:0]  e_a;
      logic [63:0] e_d;
      while (phase !== 1'b1) @(negedge clk);
      data = hi; addr = a; msel = ms; srch_n = 1'b1;
      cs_n = hi_act ? 1'b0 : 1'b1; wr_n = hi_act ? 1'b0 : 1'b1;
      @(negedge clk);
      data = lo; cs_n = c_n; wr_n = w_n; srch_n = s_n;
      // reference model
      if (m_fast) m_hold = hi;
      act = !c_n && !w_n; legal = (ms < 4'd12); twide = !a[5];
      e_vld = 1'b0; e_err = act && !legal; e_d = '0;
      e_a = m_fast ? {a[5:1], 1'b0} : a;
      if (act && legal) begin
         if (!m_fast && twide && a[0]) m_hold = lo;
         else begin
            e_vld = 1'b1;
            e_d = twide ? {m_hold, lo} : {32'h0, lo};
         end
      end
      e_srch = e_vld && twide && (e_a == 6'h00) && !s_n;
      @(negedge clk);
      check("R2/R3/R5 write pulse", {63'h0, vld}, {63'h0, e_vld});
      check("R9 illegal code flag", {63'h0, err}, {63'h0, e_err});
      if (e_vld) begin
         check("R3/R4 target width", {63'h0, wide}, {63'h0, twide});
         check("R4/R6 issued address", {58'h0, oaddr}, {58'h0, e_a});
         check("R1/R3/R5 issued data", odata, e_d);
         check("R8 mask code", {60'h0, omsel}, {60'h0, ms});
         check("R10 search launch", {63'h0, srch}, {63'h0, e_srch});
         if (!twide && e_a == 6'h3E) m_fast = lo[0];
      end
      idle();
      @(negedge clk);
      check("R11 pulse width", {63'h0, vld}, 64'h0);
      check("R7 mode state", {63'h0, fast}, {63'h0, m_fast});
   endtask

   initial begin
      #400000;
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_2024));
      idle();
      repeat (4) @(negedge clk);
      check("R1 reset pulse", {63'h0, vld}, 64'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 reset mode", {63'h0, fast}, 64'h0);
      check("R1 reset error flag", {63'h0, err}, 64'h0);
      // R1: lower half without prior upper gives zero upper bits
      xfer(0, 0, 6'h02, 32'hA5A5_0001, 32'hFFFF_FFFF, 4'd0, 1, 0);
      // R3: upper then lower pairing
      xfer(0, 0, 6'h05, 32'h1234_5678, 32'h0, 4'd1, 1, 0);
      xfer(0, 0, 6'h04, 32'h9ABC_DEF0, 32'h0, 4'd2, 1, 0);
      // R2: activity only at the high-phase edge, deselected at low edge
      xfer(1, 0, 6'h21, 32'h0BAD_0BAD, 32'h1111_2222, 4'd3, 0, 1);
      xfer(0, 1, 6'h21, 32'h0BAD_0BAD, 32'h1111_2222, 4'd3, 0, 1);
      // R4: 32-bit register
      xfer(0, 0, 6'h21, 32'hCAFE_F00D, 32'h0, 4'd11, 1, 0);
      // R9: illegal code on an upper half leaves the stored half alone
      xfer(0, 0, 6'h07, 32'hDEAD_BEEF, 32'h0, 4'd13, 1, 0);
      xfer(0, 0, 6'h06, 32'h0000_0042, 32'h0, 4'd0, 1, 0);
      xfer(0, 0, 6'h21, 32'h5555_5555, 32'h0, 4'd15, 1, 0);
      // R10: search with comparand write, and ignored elsewhere
      xfer(0, 0, 6'h01, 32'h0000_00C0, 32'h0, 4'd4, 1, 0);
      xfer(0, 0, 6'h00, 32'h0000_00C1, 32'h0, 4'd5, 0, 0);
      xfer(0, 0, 6'h08, 32'h0000_00C2, 32'h0, 4'd5, 0, 0);
      xfer(0, 0, 6'h3E, 32'h0000_0000, 32'h0, 4'd5, 0, 0);
      // R7: enter fast mode
      xfer(0, 0, 6'h3E, 32'h0000_0001, 32'h0, 4'd0, 1, 0);
      // R5/R6: fast-mode wide and narrow, address LSB ignored
      xfer(0, 0, 6'h05, 32'h7777_8888, 32'h3333_4444, 4'd6, 1, 0);
      xfer(0, 0, 6'h23, 32'h1357_9BDF, 32'hEEEE_EEEE, 4'd7, 1, 0);
      xfer(0, 0, 6'h01, 32'h0246_8ACE, 32'hFEED_FACE, 4'd8, 0, 0);
      xfer(0, 0, 6'h3F, 32'h0000_0000, 32'h0, 4'd9, 1, 0);
      // random mix
      for (int i = 0; i < 400; i++) begin
         logic [5:0] a;
         logic [3:0] ms;
         int unsigned r;
         r  = $urandom_range(0, 9);
         a  = (r == 0) ? 6'h3E : (r == 1) ? 6'h00 : (r == 2) ? 6'h01 : 6'($urandom);
         ms = ($urandom_range(0, 9) < 8) ? 4'($urandom_range(0, 11)) : 4'($urandom);
         xfer(($urandom_range(0, 9) == 0), ($urandom_range(0, 9) == 0), a,
              $urandom, $urandom, ms, 1'($urandom), 1'($urandom));
      end
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule